// File: doc/BRIEF.md
# Upper RAM and SFR Access Decoder

This block steers each on-chip data-memory access of an 8-bit controller to one of two stores: a 256-byte internal RAM, or a special-function-register (SFR) space. The lower half of the address range always belongs to RAM. The upper half (80H to FFH) is claimed by two physically separate stores. The addressing mode of the access, not the address, decides which one is reached. A direct access to the upper half reaches the SFRs. An indirect access, including stack pushes and pops, reaches the upper RAM bytes.

The block accepts one access per cycle. It presents an address, a mode flag, read and write strobes and write data. It returns read data in the same cycle and drives select and write lines for the RAM array and for the SFR bus. A short, parameterized list of SFR addresses is held as real registers, each with its own reset value and writable-bit mask. Every other SFR address is unimplemented: a read from it returns 00H and a write to it is dropped. The default configuration implements A0H, a port 2 latch that resets to FFH, and 8EH, an auxiliary control register whose only writable bit is bit 0.

Top module: `dmem_access_dec`

## Requirements
- R1: An access to an address in 00H..7FH selects the RAM (ram_cs_o=1, sfr_cs_o=0) for both values of indir_i.
- R2: A direct access (indir_i=0) to an address in 80H..FFH selects the SFR bus (sfr_cs_o=1, ram_cs_o=0).
- R3: An indirect access (indir_i=1) to an address in 80H..FFH selects the RAM. Bytes written this way, such as a stack growing toward FFH, read back through the indirect path.
- R4: An indirect write to A0H changes RAM byte A0H and leaves the SFR at A0H unchanged. A direct write to A0H changes the SFR and leaves RAM byte A0H unchanged.
- R5: Writes take effect at the rising clock edge. Reads are combinational, so rdata_o shows the addressed byte in the same cycle, and a byte written in one cycle is read back in the next.
- R6: A direct read of an unimplemented SFR address returns 00H. A direct write to such an address changes no implemented SFR and no RAM byte.
- R7: After reset, the SFR at A0H reads FFH and the SFR at 8EH reads 00H.
- R8: When wr_i and rd_i are both high, only the write is performed and rdata_o is 00H. When rd_i is low, rdata_o is 00H. With no strobe, every select and write line is low.
- R9: ram_we_o is high only for a write routed to RAM. sfr_we_o is high only for a write routed to the SFR bus. sfr_re_o is high only for a read routed to the SFR bus.
- R10: A write to the SFR at 8EH stores only bit 0. The other bits read back as 0 (writing FFH reads back 01H).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Access address |
| indir_i | input | 1 | 1 = indirect or stack access, 0 = direct access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| ram_cs_o | output | 1 | RAM array selected |
| ram_we_o | output | 1 | RAM array write |
| sfr_cs_o | output | 1 | SFR bus selected |
| sfr_we_o | output | 1 | SFR bus write |
| sfr_re_o | output | 1 | SFR bus read |

## Verification
The hardest case to show from the ports is that one store was left alone while the other, at the same address, was written. Nothing at the ports reveals a byte that was not addressed. The stimulus therefore first loads different values into RAM byte A0H and SFR A0H. It then writes through one mode and reads back through the other mode. The same cross-mode read-back is used after writes to an unimplemented SFR address, to show that the RAM byte sharing that address kept its value.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_RAM = 2'd1, TGT_SFR = 2'd2} tgt_e;
endpackage

// File: rtl/dmem_route.sv
module dmem_route
  import dmem_pkg::*;
(
  input  addr_t addr_i,
  input  logic  indir_i,
  input  logic  active_i,
  output tgt_e  tgt_o
);
  localparam int unsigned TOP_BIT = ADDR_W - 1;

  always_comb begin
    tgt_o = TGT_NONE;
    if (active_i) begin
      if (!addr_i[TOP_BIT] || indir_i) tgt_o = TGT_RAM;
      else                             tgt_o = TGT_SFR;
    end
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
  import dmem_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  addr_t addr_i,
  input  data_t wdata_i,
  output data_t rdata_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  data_t mem_q [DEPTH];
  logic [IDX_W-1:0] idx;
  assign idx = addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx] <= wdata_i;
  end

  assign rdata_o = mem_q[idx];

  AST_RAM_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(idx)] == $past(wdata_i)); // R5
endmodule

// File: rtl/dmem_sfr_bank.sv
module dmem_sfr_bank
  import dmem_pkg::*;
#(
  parameter int unsigned NUM_SFR = 2,
  parameter logic [NUM_SFR*DATA_W-1:0] SFR_ADDRS = {8'h8E, 8'hA0},
  parameter logic [NUM_SFR*DATA_W-1:0] SFR_RST   = {8'h00, 8'hFF},
  parameter logic [NUM_SFR*DATA_W-1:0] SFR_WMASK = {8'h01, 8'hFF}
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  addr_t addr_i,
  input  data_t wdata_i,
  output data_t rdata_o
);
  logic [NUM_SFR-1:0]             hit;
  logic [NUM_SFR-1:0][DATA_W-1:0] sfr_q;
  logic [NUM_SFR-1:0][DATA_W-1:0] rd_term;

  for (genvar g = 0; g < NUM_SFR; g++) begin : g_sfr
    localparam data_t ADDR_G = SFR_ADDRS[g*DATA_W +: DATA_W];
    localparam data_t RST_G  = SFR_RST[g*DATA_W +: DATA_W];
    localparam data_t MASK_G = SFR_WMASK[g*DATA_W +: DATA_W];

    assign hit[g] = (addr_i == ADDR_G);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             sfr_q[g] <= RST_G & MASK_G;
      else if (we_i && hit[g]) sfr_q[g] <= wdata_i & MASK_G;
    end

    assign rd_term[g] = hit[g] ? sfr_q[g] : '0;
  end

  // unimplemented addresses fall through as 00H
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SFR; i++) rdata_o = rdata_o | rd_term[i];
  end

  AST_SFR_UNIMPL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit == '0) |=> $stable(sfr_q)); // R6
  AST_SFR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sfr_q)); // R4
  AST_SFR_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R6
endmodule

// File: rtl/dmem_access_dec.sv
module dmem_access_dec
  import dmem_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 256,
  parameter int unsigned NUM_SFR   = 2,
  parameter logic [NUM_SFR*DATA_W-1:0] SFR_ADDRS = {8'h8E, 8'hA0},
  parameter logic [NUM_SFR*DATA_W-1:0] SFR_RST   = {8'h00, 8'hFF},
  parameter logic [NUM_SFR*DATA_W-1:0] SFR_WMASK = {8'h01, 8'hFF}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       indir_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ram_cs_o,
  output logic       ram_we_o,
  output logic       sfr_cs_o,
  output logic       sfr_we_o,
  output logic       sfr_re_o
);
  tgt_e  tgt;
  logic  active, rd_eff;
  data_t ram_rdata, sfr_rdata;

  assign active = rd_i | wr_i;
  assign rd_eff = rd_i & ~wr_i;  // write wins a shared cycle

  dmem_route u_route (
    .addr_i   (addr_i),
    .indir_i  (indir_i),
    .active_i (active),
    .tgt_o    (tgt)
  );

  assign ram_cs_o = (tgt == TGT_RAM);
  assign sfr_cs_o = (tgt == TGT_SFR);
  assign ram_we_o = ram_cs_o & wr_i;
  assign sfr_we_o = sfr_cs_o & wr_i;
  assign sfr_re_o = sfr_cs_o & rd_eff;

  dmem_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we_o),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  dmem_sfr_bank #(
    .NUM_SFR   (NUM_SFR),
    .SFR_ADDRS (SFR_ADDRS),
    .SFR_RST   (SFR_RST),
    .SFR_WMASK (SFR_WMASK)
  ) u_sfr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sfr_we_o),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (sfr_rdata)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_eff) rdata_o = ram_cs_o ? ram_rdata : sfr_rdata;
  end

  AST_LOW_HALF_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !addr_i[7]) |-> (ram_cs_o && !sfr_cs_o)); // R1
  AST_DIRECT_UPPER_SFR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && addr_i[7] && !indir_i) |-> (sfr_cs_o && !ram_cs_o)); // R2
  AST_INDIRECT_UPPER_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && addr_i[7] && indir_i) |-> (ram_cs_o && !sfr_cs_o)); // R3
  AST_NO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || wr_i) |-> (rdata_o == 8'h00)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !(ram_cs_o || sfr_cs_o || ram_we_o || sfr_we_o || sfr_re_o)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_we_o, sfr_we_o, sfr_re_o})); // R9
endmodule

// File: tb/dmem_access_dec_test.sv
module dmem_access_dec_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 0, rst_ni = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       indir = 0, rd = 0, wr = 0;
  logic [7:0] rdata;
  logic       ram_cs, ram_we, sfr_cs, sfr_we, sfr_re;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_access_dec uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .indir_i(indir),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .ram_cs_o(ram_cs), .ram_we_o(ram_we), .sfr_cs_o(sfr_cs),
    .sfr_we_o(sfr_we), .sfr_re_o(sfr_re)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 time unit later; write lands at next posedge
  task automatic do_wr(logic ind, logic [7:0] a, logic [7:0] d, string req,
                       logic exp_ram);
    @(negedge clk);
    indir = ind; addr = a; wdata = d; wr = 1; rd = 0;
    #1;
    chk(req, {3'b0, ram_cs, ram_we, sfr_cs, sfr_we, sfr_re},
        {3'b0, exp_ram, exp_ram, !exp_ram, !exp_ram, 1'b0});
    @(posedge clk);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_rd(logic ind, logic [7:0] a, logic [7:0] exp, string req,
                       logic exp_ram);
    @(negedge clk);
    indir = ind; addr = a; rd = 1; wr = 0;
    #1;
    chk(req, rdata, exp);
    chk(req, {4'b0, ram_cs, ram_we, sfr_cs, sfr_re},
        {4'b0, exp_ram, 1'b0, !exp_ram, !exp_ram});
    @(negedge clk);
    rd = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R8 idle", {3'b0, ram_cs, ram_we, sfr_cs, sfr_we, sfr_re}, 8'h00);
    chk("R8 idle rdata", rdata, 8'h00);
    do_rd(0, 8'hA0, 8'hFF, "R7 port2 reset", 0);
    do_rd(0, 8'h8E, 8'h00, "R7 aux reset", 0);
  endtask

  task automatic t_lower;
    do_wr(1, 8'h25, 8'h5A, "R1 indirect low write", 1);
    do_rd(0, 8'h25, 8'h5A, "R1 direct low read", 1);
    do_wr(0, 8'h7F, 8'hC7, "R1 direct 7F write", 1);
    do_rd(1, 8'h7F, 8'hC7, "R1 indirect 7F read", 1);
  endtask

  task automatic t_cross;
    do_wr(0, 8'hA0, 8'h3C, "R2 direct A0 write", 0);
    do_rd(0, 8'hA0, 8'h3C, "R2 direct A0 read", 0);
    do_wr(1, 8'hA0, 8'hC3, "R3 indirect A0 write", 1);
    do_rd(1, 8'hA0, 8'hC3, "R3 indirect A0 read", 1);
    do_rd(0, 8'hA0, 8'h3C, "R4 port2 kept after indirect write", 0);
    do_wr(0, 8'hA0, 8'h11, "R4 direct A0 rewrite", 0);
    do_rd(1, 8'hA0, 8'hC3, "R4 ram A0 kept after direct write", 1);
    do_rd(0, 8'hA0, 8'h11, "R4 port2 new value", 0);
  endtask

  task automatic t_stack;
    for (int i = 0; i < 4; i++)
      do_wr(1, 8'hFC + 8'(i), 8'h90 + 8'(i), "R3 push", 1);
    for (int i = 3; i >= 0; i--)
      do_rd(1, 8'hFC + 8'(i), 8'h90 + 8'(i), "R3 pop", 1);
  endtask

  task automatic t_back_to_back;
    // R5: write in one cycle, read in the very next
    @(negedge clk);
    indir = 1; addr = 8'h40; wdata = 8'hE1; wr = 1; rd = 0;
    @(negedge clk);
    wr = 0; rd = 1;
    #1;
    chk("R5 next-cycle read", rdata, 8'hE1);
    addr = 8'h25;
    #1;
    chk("R5 combinational read", rdata, 8'h5A);
    @(negedge clk);
    rd = 0;
  endtask

  task automatic t_unimpl;
    do_wr(1, 8'h90, 8'h77, "R3 ram 90 write", 1);
    do_wr(0, 8'h90, 8'hAA, "R6 unimpl write", 0);
    do_rd(0, 8'h90, 8'h00, "R6 unimpl read 00", 0);
    do_rd(1, 8'h90, 8'h77, "R6 ram 90 untouched", 1);
    do_rd(0, 8'hA0, 8'h11, "R6 port2 untouched", 0);
    do_rd(0, 8'h8E, 8'h00, "R6 aux untouched", 0);
  endtask

  task automatic t_mask;
    do_wr(0, 8'h8E, 8'hFF, "R10 aux write FF", 0);
    do_rd(0, 8'h8E, 8'h01, "R10 aux bit0 only", 0);
    do_wr(0, 8'h8E, 8'hFE, "R10 aux write FE", 0);
    do_rd(0, 8'h8E, 8'h00, "R10 aux cleared", 0);
  endtask

  task automatic t_both;
    @(negedge clk);
    indir = 1; addr = 8'h33; wdata = 8'h6D; wr = 1; rd = 1;
    #1;
    chk("R8 rd+wr rdata zero", rdata, 8'h00);
    chk("R9 rd+wr strobes", {5'b0, ram_we, sfr_re, sfr_we}, 8'h04);
    @(negedge clk);
    wr = 0; rd = 0;
    do_rd(1, 8'h33, 8'h6D, "R8 write performed", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_lower();
    t_cross();
    t_stack();
    t_back_to_back();
    t_unimpl();
    t_mask();
    t_both();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule